// File: doc/BRIEF.md
# Multi-Mode Load Address Sequencer

This block carries out a single word load using one of four ways of forming the address, then returns the loaded word to a register file through write ports. A request arrives over a valid/ready handshake. It carries a mode code, two register values (a base and an index), a 16-bit signed offset, the destination register number, and the number of the base register. The sequencer forms the effective address and reads a synchronous word memory. Read data from that memory arrives one cycle after the read strobe. The sequencer then drives one or two register writes and pulses a completion flag.

The request side is the only streaming interface. `req_ready` is high exactly while the sequencer is idle. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. While an operation is in flight, `req_ready` stays low, so the requester is held back and anything presented on the request pins is not taken. The memory port, the write ports and `done` are plain control and data pins with no back-pressure.

Top module: `ldaddr_seq`

## Requirements
- R1: `req_ready` is high only while idle, and a request is taken only on an edge with `req_valid` and `req_ready` both high. Request pins driven while `req_ready` is low cause no extra memory read, register write or `done` pulse, and do not change the running operation.
- R2: Mode code 0 (register plus offset) reads memory at base + sign-extended offset, and writes the word read to the destination register on write port A.
- R3: Mode code 1 (two-register sum) reads memory at base + index, ignoring the offset, and writes the word read to the destination register on port A.
- R4: Mode code 2 (load with base update) reads at base + sign-extended offset. In one and the same cycle, it writes the word read to the destination on port A and the full unaligned sum base + offset to the base register on port B.
- R5: In mode 2, when the destination number equals the base register number, only port A writes (the loaded word wins), and port B stays idle.
- R6: Mode code 3 (pointer in memory) first reads at base + sign-extended offset. The word returned is a pointer, and the next cycle reads at that pointer. The second word read goes to the destination on port A, and exactly two reads occur.
- R7: Every memory read address has bits [1:0] equal to 0; the low two bits of any computed address or pointer are dropped.
- R8: The first read strobe is asserted two cycles after the accepting edge, and the second read (mode 3 only) follows in the next cycle. The register write occurs one cycle after the last read strobe. `done` is high for exactly one cycle, the cycle after the write.
- R9: After reset, `req_ready` is high, and `mem_rd`, `wa_en`, `wb_en` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can transfer |
| req_mode | input | 2 | 0 reg+offset, 1 reg+reg, 2 update, 3 pointer |
| req_base | input | DW | Base register value |
| req_index | input | DW | Index register value (mode 1) |
| req_off | input | OW | Signed offset |
| req_dst | input | RW | Destination register number |
| req_upd_id | input | RW | Base register number for write-back (mode 2) |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | DW | Word-aligned byte address |
| mem_rdata | input | DW | Read data, valid the cycle after `mem_rd` |
| wa_en | output | 1 | Write port A enable (loaded word) |
| wa_id | output | RW | Write port A register number |
| wa_data | output | DW | Write port A data |
| wb_en | output | 1 | Write port B enable (base update) |
| wb_id | output | RW | Write port B register number |
| wb_data | output | DW | Write port B data |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong internal state shows up within a few cycles of the accepting edge. It appears as a read strobe in the wrong cycle, a missing or extra second read, or an address that is off or unaligned. It can also appear as a write landing a cycle early or late, or as `done` arriving at the wrong time or lasting more than one cycle. The bench rebuilds every address and loaded word from a closed-form memory content function. It checks the exact cycle of each read, write and completion against the accepting edge, so a state skipped or repeated is seen in that same operation. A few idle cycles after each completion also expose any stray strobe that a request pushed while busy might have caused.

// File: rtl/ldseq_pkg.sv
package ldseq_pkg;
  typedef enum logic [1:0] {
    MD_BASE     = 2'd0,
    MD_INDEX    = 2'd1,
    MD_UPDATE   = 2'd2,
    MD_INDIRECT = 2'd3
  } ld_mode_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ADDR  = 3'd1,
    S_READ1 = 3'd2,
    S_READ2 = 3'd3,
    S_WB    = 3'd4
  } ld_state_e;
endpackage

// File: rtl/ldseq_agen.sv
module ldseq_agen
  import ldseq_pkg::*;
#(
  parameter int DW = 32,
  parameter int OW = 16
) (
  input  ld_mode_e        mode,
  input  logic [DW-1:0]   base,
  input  logic [DW-1:0]   index,
  input  logic [OW-1:0]   off,
  output logic [DW-1:0]   sum
);
  localparam int EXT_W = DW - OW;

  logic [DW-1:0] off_ext;
  logic [DW-1:0] addend;

  // offset widened with its sign bit
  assign off_ext = {{EXT_W{off[OW-1]}}, off};
  // two-register mode uses the index, every other mode the offset
  assign addend  = (mode == MD_INDEX) ? index : off_ext;
  assign sum     = base + addend;
endmodule

// File: rtl/ldseq_ctrl.sv
module ldseq_ctrl
  import ldseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      two_reads,
  output ld_state_e st,
  output logic      done
);
  ld_state_e st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE:  if (start) st_nx = S_ADDR;
      S_ADDR:  st_nx = S_READ1;
      S_READ1: st_nx = two_reads ? S_READ2 : S_WB;
      S_READ2: st_nx = S_WB;
      S_WB:    st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      done <= 1'b0;
    end else begin
      st   <= st_nx;
      done <= (st == S_WB);
    end
  end

  // second read only directly after the first
  p_read2_follows_read1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_READ2 |-> $past(st) == S_READ1);
  // completion is a single-cycle pulse
  p_done_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // a new operation only starts from idle
  p_addr_from_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_ADDR |-> $past(st) == S_IDLE && $past(start));
endmodule

// File: rtl/ldseq_wport.sv
module ldseq_wport
  import ldseq_pkg::*;
#(
  parameter int DW = 32,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_now,
  input  ld_mode_e      mode,
  input  logic [RW-1:0] dst,
  input  logic [RW-1:0] upd_id,
  input  logic [DW-1:0] load_word,
  input  logic [DW-1:0] upd_val,
  output logic          wa_en,
  output logic [RW-1:0] wa_id,
  output logic [DW-1:0] wa_data,
  output logic          wb_en,
  output logic [RW-1:0] wb_id,
  output logic [DW-1:0] wb_data
);
  logic id_clash;

  assign id_clash = (dst == upd_id);

  assign wa_en   = wr_now;
  assign wa_id   = dst;
  assign wa_data = load_word;

  // base write-back only in update mode, dropped when it targets the destination
  assign wb_en   = wr_now && (mode == MD_UPDATE) && !id_clash;
  assign wb_id   = upd_id;
  assign wb_data = upd_val;

  p_upd_with_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> wa_en);
  p_no_dual_same_reg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> wb_id != wa_id);
endmodule

// File: rtl/ldaddr_seq.sv
module ldaddr_seq
  import ldseq_pkg::*;
#(
  parameter int DW = 32,
  parameter int OW = 16,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_mode,
  input  logic [DW-1:0] req_base,
  input  logic [DW-1:0] req_index,
  input  logic [OW-1:0] req_off,
  input  logic [RW-1:0] req_dst,
  input  logic [RW-1:0] req_upd_id,
  output logic          mem_rd,
  output logic [DW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          wa_en,
  output logic [RW-1:0] wa_id,
  output logic [DW-1:0] wa_data,
  output logic          wb_en,
  output logic [RW-1:0] wb_id,
  output logic [DW-1:0] wb_data,
  output logic          done
);
  localparam int LSB_DROP = 2;

  ld_state_e     st;
  ld_mode_e      mode_q;
  logic [DW-1:0] base_q, index_q, ea_q, ea_w;
  logic [OW-1:0] off_q;
  logic [RW-1:0] dst_q, upd_q;
  logic          accept;
  logic [DW-1:0] addr_raw;

  assign req_ready = (st == S_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MD_BASE;
      base_q  <= '0;
      index_q <= '0;
      off_q   <= '0;
      dst_q   <= '0;
      upd_q   <= '0;
      ea_q    <= '0;
    end else begin
      if (accept) begin
        mode_q  <= ld_mode_e'(req_mode);
        base_q  <= req_base;
        index_q <= req_index;
        off_q   <= req_off;
        dst_q   <= req_dst;
        upd_q   <= req_upd_id;
      end
      if (st == S_ADDR) ea_q <= ea_w;
    end
  end

  ldseq_agen #(.DW(DW), .OW(OW)) i_agen (
    .mode (mode_q),
    .base (base_q),
    .index(index_q),
    .off  (off_q),
    .sum  (ea_w)
  );

  ldseq_ctrl i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .two_reads(mode_q == MD_INDIRECT),
    .st       (st),
    .done     (done)
  );

  // second read takes the pointer straight from the returned word
  assign mem_rd   = (st == S_READ1) || (st == S_READ2);
  assign addr_raw = (st == S_READ2) ? mem_rdata : ea_q;
  assign mem_addr = {addr_raw[DW-1:LSB_DROP], {LSB_DROP{1'b0}}};

  ldseq_wport #(.DW(DW), .RW(RW)) i_wport (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_now   (st == S_WB),
    .mode     (mode_q),
    .dst      (dst_q),
    .upd_id   (upd_q),
    .load_word(mem_rdata),
    .upd_val  (ea_q),
    .wa_en    (wa_en),
    .wa_id    (wa_id),
    .wa_data  (wa_data),
    .wb_en    (wb_en),
    .wb_id    (wb_id),
    .wb_data  (wb_data)
  );

  p_addr_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> mem_addr[1:0] == 2'b00);
  p_busy_not_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || wa_en || done) |-> !req_ready || done);
  p_done_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wa_en |=> done);
  p_write_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wa_en |-> $past(mem_rd));
endmodule

// File: tb/test_ldaddr_seq.sv
module test_ldaddr_seq;
  localparam int DW = 32;
  localparam int OW = 16;
  localparam int RW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_mode = '0;
  logic [DW-1:0] req_base = '0, req_index = '0;
  logic [OW-1:0] req_off = '0;
  logic [RW-1:0] req_dst = '0, req_upd_id = '0;
  logic          mem_rd;
  logic [DW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;
  logic          wa_en, wb_en, done;
  logic [RW-1:0] wa_id, wb_id;
  logic [DW-1:0] wa_data, wb_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // monitor log
  int          nrd, nwa, nwb, ndone;
  int          rd_cyc[2];
  logic [31:0] rd_adr[2];
  int          wa_cyc, wb_cyc, done_cyc;
  logic [4:0]  got_wa_id, got_wb_id;
  logic [31:0] got_wa_d, got_wb_d;

  always #10 clk = ~clk;

  ldaddr_seq #(.DW(DW), .OW(OW), .RW(RW)) i_ldaddr_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_base(req_base), .req_index(req_index),
    .req_off(req_off), .req_dst(req_dst), .req_upd_id(req_upd_id),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .wa_en(wa_en), .wa_id(wa_id), .wa_data(wa_data),
    .wb_en(wb_en), .wb_id(wb_id), .wb_data(wb_data), .done(done)
  );

  function automatic logic [31:0] memval(input logic [5:0] w);
    return {26'd0, w} * 32'h0104_0C11 + 32'h3C00_0A0B;
  endfunction

  function automatic logic [31:0] sx(input logic [15:0] o);
    return {{16{o[15]}}, o};
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd) mem_rdata <= memval(mem_addr[7:2]);
  end

  always @(negedge clk) begin
    if (mem_rd) begin
      if (nrd < 2) begin
        rd_adr[nrd] = mem_addr;
        rd_cyc[nrd] = cyc;
      end
      nrd = nrd + 1;
    end
    if (wa_en) begin
      nwa = nwa + 1; wa_cyc = cyc; got_wa_id = wa_id; got_wa_d = wa_data;
    end
    if (wb_en) begin
      nwb = nwb + 1; wb_cyc = cyc; got_wb_id = wb_id; got_wb_d = wb_data;
    end
    if (done) begin
      ndone = ndone + 1; done_cyc = cyc;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] m, input logic [31:0] ra, input logic [31:0] rb,
                        input logic [15:0] off, input logic [4:0] dst, input logic [4:0] bid,
                        input logic intrude);
    int acc;
    int last_rd;
    int waited;
    logic [31:0] ea, ptr, exp_d, a0;
    logic        upd;
    nrd = 0; nwa = 0; nwb = 0; ndone = 0;
    chk(req_ready == 1'b1, "R1 ready when idle", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_mode = m; req_base = ra; req_index = rb;
    req_off = off; req_dst = dst; req_upd_id = bid;
    @(negedge clk);
    acc = cyc;
    if (intrude) begin
      // push a different request while busy: must not be taken (R1)
      req_mode = 2'd3; req_base = 32'h0000_0040; req_off = 16'h0008;
      req_dst = 5'd31; req_upd_id = 5'd30;
      chk(req_ready == 1'b0, "R1 ready low while busy", {31'd0, req_ready}, 32'd0);
      @(negedge clk);
      chk(req_ready == 1'b0, "R1 ready low while busy", {31'd0, req_ready}, 32'd0);
    end
    req_valid = 1'b0;
    waited = 0;
    while (ndone == 0 && waited < 20) begin
      @(negedge clk);
      waited++;
    end
    repeat (3) @(negedge clk);

    ea    = (m == 2'd1) ? ra + rb : ra + sx(off);
    a0    = {ea[31:2], 2'b00};
    ptr   = memval(ea[7:2]);
    exp_d = (m == 2'd3) ? memval(ptr[7:2]) : memval(ea[7:2]);
    upd   = (m == 2'd2) && (dst != bid);
    last_rd = (m == 2'd3) ? acc + 2 : acc + 1;

    chk(ndone == 1, "R8 exactly one done cycle", ndone, 1);
    chk(nrd == ((m == 2'd3) ? 2 : 1), "R6 read count", nrd, (m == 2'd3) ? 2 : 1);
    chk(rd_adr[0] == a0, (m == 2'd1) ? "R3 first address" : "R2 first address", rd_adr[0], a0);
    chk(rd_adr[0][1:0] == 2'b00, "R7 aligned first address", rd_adr[0], a0);
    chk(rd_cyc[0] == acc + 1, "R8 first read cycle", rd_cyc[0], acc + 1);
    if (m == 2'd3) begin
      chk(rd_adr[1] == {ptr[31:2], 2'b00}, "R6 pointer address", rd_adr[1], {ptr[31:2], 2'b00});
      chk(rd_cyc[1] == acc + 2, "R8 second read cycle", rd_cyc[1], acc + 2);
    end
    chk(nwa == 1, "R2 one port A write", nwa, 1);
    chk(got_wa_d == exp_d, "R2 loaded word", got_wa_d, exp_d);
    chk(got_wa_id == dst, "R2 destination", {27'd0, got_wa_id}, {27'd0, dst});
    chk(wa_cyc == last_rd + 1, "R8 write cycle", wa_cyc, last_rd + 1);
    chk(done_cyc == wa_cyc + 1, "R8 done after write", done_cyc, wa_cyc + 1);
    if (upd) begin
      chk(nwb == 1, "R4 one port B write", nwb, 1);
      chk(got_wb_d == ra + sx(off), "R4 base update value", got_wb_d, ra + sx(off));
      chk(got_wb_id == bid, "R4 base update id", {27'd0, got_wb_id}, {27'd0, bid});
      chk(wb_cyc == wa_cyc, "R4 same cycle dual write", wb_cyc, wa_cyc);
    end else begin
      chk(nwb == 0, (m == 2'd2) ? "R5 clash drops port B" : "R4 no port B", nwb, 0);
    end
  endtask

  initial begin
    logic [15:0] offs[6];
    logic [31:0] bases[2];
    offs  = '{16'h0000, 16'h0004, 16'hFFFC, 16'h7FFD, 16'h8000, 16'h0013};
    bases = '{32'h0000_0100, 32'hFFFF_FF03};
    nrd = 0; nwa = 0; nwb = 0; ndone = 0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready in reset", {31'd0, req_ready}, 32'd1);
    chk({mem_rd, wa_en, wb_en, done} == 4'd0, "R9 outputs quiet in reset",
        {28'd0, mem_rd, wa_en, wb_en, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({mem_rd, wa_en, wb_en, done} == 4'd0, "R9 outputs quiet after reset",
        {28'd0, mem_rd, wa_en, wb_en, done}, 32'd0);
    for (int m = 0; m < 4; m++) begin
      for (int o = 0; o < 6; o++) begin
        for (int r = 0; r < 2; r++) begin
          logic [4:0] d;
          logic [4:0] b;
          d = 5'(m * 6 + o + r);
          b = (r == 1 && o == 2) ? d : d ^ 5'h11;
          run_op(2'(m), bases[r], 32'h0000_0025 + 32'(o * 12), offs[o], d, b, 1'b0);
        end
      end
    end
    // R1: requests pushed while busy are not taken, in each mode
    for (int m = 0; m < 4; m++)
      run_op(2'(m), 32'h0000_0080, 32'h0000_0011, 16'h0010, 5'd3, 5'd9, 1'b1);
    // R5: explicit clash in update mode
    run_op(2'd2, 32'h0000_0200, 32'h0, 16'h0024, 5'd7, 5'd7, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule